// File: doc/BRIEF.md
# Bus-Attached Serial Port with Receive and Transmit Queues

This block is a byte-wide serial port that a processor reaches through an 8-bit Wishbone slave with a 12-bit address. Software writes characters into a transmit queue and reads received characters out of a receive queue. It polls a four-bit status word, or arms two interrupt conditions that are ORed onto a single request line. The serial side sends and receives 8N1 frames: one low start bit, eight data bits with the least significant first, and one high stop bit. The transmitter and the receiver share one sample tick, produced by a programmable divider, and every bit lasts sixteen ticks.

Inside the block, data moves through valid/ready streams. The transmit queue accepts a byte only when it has room. A bus write to a full transmit queue is acknowledged and the byte is discarded. The transmitter takes a byte when it is idle and the queue offers one. The receiver cannot be stalled, because the line keeps running: when a frame completes and the receive queue has no room, that byte is lost. A bus read of an empty receive queue returns zero and leaves the queue unchanged.

Registers sit 8 bytes apart. Every bit of the 12-bit address is compared when a register is selected.

Top module: `uart_bus_port`

## Requirements
- R1: `ack_o` is low in the cycle a request (cyc_i and stb_i high) first appears. It rises after the next clock edge and stays high while cyc_i and stb_i stay high. It is low whenever either of them is low. After stb_i falls, one clock edge must pass before a new request is taken.
- R2: A write to offset 0x000 queues dat_i for transmission. txd_o idles high. Each byte goes out as a low start bit, eight data bits LSB first and a high stop bit, each bit lasting 16*(divisor+1) clocks, and queued bytes are sent in order.
- R3: A read of offset 0x008 returns the oldest received byte and removes it from the queue. When the queue is empty, the read returns 0x00.
- R4: A read of offset 0x010 returns the status: bit 0 is receive queue empty, bit 1 is transmit queue empty, bit 2 is receive queue full, bit 3 is transmit queue full, and bits 7..4 are zero. The value after reset is 0x03.
- R5: Offset 0x018 is a read/write 8-bit divisor, cleared by reset. The sample tick fires once every divisor+1 clocks.
- R6: Offset 0x020 holds two interrupt enables, bit 0 for receive and bit 1 for transmit. It reads back with bits 7..2 as zero and is cleared by reset.
- R7: `irq_o` equals (receive queue not empty AND enable bit 0) OR (transmit queue empty AND enable bit 1).
- R8: Reads of any other address, including 0x000 and addresses that differ only above bit 5, return 0x00. Writes to such addresses, and writes to 0x008 and 0x010, are acknowledged and change no state.
- R9: A request that is held for several cycles pushes or pops its queue exactly once.
- R10: rxd_i passes through two flops. A start bit is accepted only if the line is still low at its midpoint, so shorter low pulses are ignored. Data bits are sampled at their middles.
- R11: A received frame whose stop bit reads low is discarded, and the receiver waits for the line to go high before it looks for the next start bit.
- R12: Each queue holds FIFO_DEPTH entries (a power of two, default 64). A byte that arrives at a full queue, from the bus or from the line, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adr_i | input | 12 | Bus byte address |
| dat_i | input | 8 | Bus write data |
| dat_o | output | 8 | Bus read data, valid while ack_o is high |
| we_i | input | 1 | Bus write enable |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Bus strobe |
| ack_o | output | 1 | Bus acknowledge |
| irq_o | output | 1 | Combined interrupt request |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input, asynchronous |

## Verification
The hardest states to reach are the two full queues and the bytes dropped at them. With the default depth, filling the receive queue would take dozens of line frames, so the bench sets the depth to four. It then sends five frames before reading. The transmit queue fills only when bus writes outrun the line. With the divisor at one, a burst of six back-to-back writes leaves the transmitter busy and the queue full, so the sixth byte must never appear on txd_o. A glitch shorter than half a bit and a frame with a low stop bit exercise the receiver's rejection paths.

// File: rtl/uart_bus_pkg.sv
package uart_bus_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFF_TXQ  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_RXQ  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 12'h020;

  localparam int ST_RX_EMPTY = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_FULL  = 3;

  typedef enum logic {BUS_IDLE, BUS_HOLD} bus_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr, count;
  logic push, pop;

  assign count     = wr_ptr - rd_ptr;
  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= in_data;
  end

  // R12: occupancy never passes the configured depth
  a_r12_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
endmodule

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R5: with a nonzero, steady divisor two ticks never sit back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor != '0 && $stable(divisor)) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       txd_o
);
  localparam int SW = (OS > 1) ? $clog2(OS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OS - 1);
  localparam int FRAME_BITS = 10;

  logic        busy;
  logic [9:0]  shreg;
  logic [3:0]  bitn;
  logic [SW-1:0] sub;

  assign in_ready = !busy;
  assign txd_o    = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      shreg <= '1;
      bitn  <= '0;
      sub   <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        shreg <= {1'b1, in_data, 1'b0};
        busy  <= 1'b1;
        bitn  <= '0;
        sub   <= '0;
      end
    end else if (tick) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (bitn == 4'(FRAME_BITS - 1)) begin
          busy <= 1'b0;
        end else begin
          shreg <= {1'b1, shreg[9:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  // R2: a frame starts only when the queue offered a byte
  a_r2_load_on_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(in_valid));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_bus_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd_async,
  output logic       out_valid,
  output logic [7:0] out_data
);
  localparam int SW = (OS > 1) ? $clog2(OS) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(OS - 1);
  localparam logic [SW-1:0] SUB_HALF = SW'(OS / 2 - 1);

  logic [1:0]    sync;
  logic          rxs;
  logic          armed;
  rx_state_e     state;
  logic [SW-1:0] sub;
  logic [2:0]    bitn;
  logic [7:0]    shreg;

  assign rxs      = sync[1];
  assign out_data = shreg;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd_async};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      armed     <= 1'b0;
      sub       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (rxs) begin
              armed <= 1'b1;
            end else if (armed) begin
              state <= RX_START;
              sub   <= '0;
            end
          end
          RX_START: begin
            if (sub == SUB_HALF) begin
              sub  <= '0;
              bitn <= '0;
              state <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_DATA: begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              shreg <= {rxs, shreg[7:1]};
              if (bitn == 3'd7) state <= RX_STOP;
              else              bitn  <= bitn + 1'b1;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          RX_STOP: begin
            if (sub == SUB_LAST) begin
              sub       <= '0;
              state     <= RX_IDLE;
              out_valid <= rxs;
              armed     <= rxs;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R10: each completed frame yields a single-cycle delivery
  a_r10_single_delivery: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R11: a delivery only follows a high stop sample
  a_r11_stop_high: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(rxs));
endmodule

// File: rtl/uart_bus_port.sv
module uart_bus_port
  import uart_bus_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] adr_i,
  input  logic [7:0]  dat_i,
  output logic [7:0]  dat_o,
  input  logic        we_i,
  input  logic        cyc_i,
  input  logic        stb_i,
  output logic        ack_o,
  output logic        irq_o,
  output logic        txd_o,
  input  logic        rxd_i
);
  bus_state_e state;
  logic       ack_q;
  logic [7:0] divisor;
  logic       ien_rx, ien_tx;
  logic       tick;

  logic       txq_in_valid, txq_in_ready, txq_out_valid, txq_out_ready;
  logic [7:0] txq_out_data;
  logic       rxq_in_valid, rxq_in_ready, rxq_out_valid, rxq_out_ready;
  logic [7:0] rxq_in_data, rxq_out_data;

  logic       take, sel_wr, sel_rd;
  logic [7:0] rd_val;
  logic       rx_pop, tx_push;

  assign take   = (state == BUS_IDLE) && cyc_i && stb_i;
  assign sel_wr = take && we_i;
  assign sel_rd = take && !we_i;
  assign ack_o  = ack_q && cyc_i && stb_i;

  assign txq_in_valid  = sel_wr && (adr_i == OFF_TXQ);
  assign rxq_out_ready = sel_rd && (adr_i == OFF_RXQ);
  assign rx_pop        = rxq_out_valid && rxq_out_ready;
  assign tx_push       = txq_in_valid && txq_in_ready;

  assign irq_o = (rxq_out_valid && ien_rx) || (!txq_out_valid && ien_tx);

  always_comb begin
    rd_val = '0;
    unique case (adr_i)
      OFF_RXQ:  rd_val = rxq_out_valid ? rxq_out_data : 8'h00;
      OFF_STAT: begin
        rd_val[ST_RX_EMPTY] = !rxq_out_valid;
        rd_val[ST_TX_EMPTY] = !txq_out_valid;
        rd_val[ST_RX_FULL]  = !rxq_in_ready;
        rd_val[ST_TX_FULL]  = !txq_in_ready;
      end
      OFF_DIV:  rd_val = divisor;
      OFF_IEN:  rd_val = {6'b0, ien_tx, ien_rx};
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BUS_IDLE;
      ack_q   <= 1'b0;
      dat_o   <= '0;
      divisor <= '0;
      ien_rx  <= 1'b0;
      ien_tx  <= 1'b0;
    end else begin
      unique case (state)
        BUS_IDLE: begin
          if (take) begin
            ack_q <= 1'b1;
            state <= BUS_HOLD;
            if (we_i) begin
              if (adr_i == OFF_DIV) divisor <= dat_i;
              if (adr_i == OFF_IEN) begin
                ien_rx <= dat_i[0];
                ien_tx <= dat_i[1];
              end
            end else begin
              dat_o <= rd_val;
            end
          end
        end
        BUS_HOLD: begin
          if (!stb_i) begin
            ack_q <= 1'b0;
            state <= BUS_IDLE;
          end
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  uart_baud_tick #(.DIV_W(8)) u_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst(rst),
    .in_valid(txq_in_valid), .in_ready(txq_in_ready), .in_data(dat_i),
    .out_valid(txq_out_valid), .out_ready(txq_out_ready), .out_data(txq_out_data)
  );

  uart_tx #(.OS(OVERSAMPLE)) u_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .in_valid(txq_out_valid), .in_ready(txq_out_ready), .in_data(txq_out_data),
    .txd_o(txd_o)
  );

  uart_rx #(.OS(OVERSAMPLE)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_async(rxd_i),
    .out_valid(rxq_in_valid), .out_data(rxq_in_data)
  );

  uart_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst(rst),
    .in_valid(rxq_in_valid), .in_ready(rxq_in_ready), .in_data(rxq_in_data),
    .out_valid(rxq_out_valid), .out_ready(rxq_out_ready), .out_data(rxq_out_data)
  );

  // R1: acknowledge only rises after a request was seen on the previous edge
  a_r1_ack_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(cyc_i && stb_i));
  // R1: acknowledge holds while the request holds
  a_r1_ack_held: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> (ack_o || !(cyc_i && stb_i)));
  // R9: at most one pop per transaction
  a_r9_single_pop: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);
  // R9: at most one push per transaction
  a_r9_single_push: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push);
endmodule

// File: tb/uart_bus_port_test.sv
module uart_bus_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int BITC = 32;   // 16 ticks * (divisor 1 + 1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] adr_i = '0;
  logic [7:0] dat_i = '0;
  logic [7:0] dat_o;
  logic we_i = 1'b0, cyc_i = 1'b0, stb_i = 1'b0;
  logic ack_o, irq_o, txd_o;
  logic rxd_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int rx_model_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bus_port #(.FIFO_DEPTH(DEPTH), .OVERSAMPLE(16)) uut (
    .clk(clk), .rst(rst), .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o),
    .we_i(we_i), .cyc_i(cyc_i), .stb_i(stb_i), .ack_o(ack_o),
    .irq_o(irq_o), .txd_o(txd_o), .rxd_i(rxd_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic [11:0] a, input logic we, input logic [7:0] wd,
                          input int hold, output logic [7:0] rd);
    @(negedge clk);
    adr_i = a; we_i = we; dat_i = wd; cyc_i = 1'b1; stb_i = 1'b1;
    @(posedge clk); #1;
    rd = dat_o;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
    @(posedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    logic [7:0] unused_rd;
    bus_xfer(a, 1'b1, d, 0, unused_rd);
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_xfer(a, 1'b0, 8'h00, 0, v);
    check(v === exp, req, v, exp);
  endtask

  // scoreboard driver for the transmit side
  task automatic tx_send(input logic [7:0] d, input bit accepted);
    if (accepted) txq.push_back(d);
    wr(12'h000, d);
  endtask

  // scoreboard driver for the receive side
  task automatic line_frame(input logic [7:0] d, input bit stop_ok);
    @(negedge clk); rxd_i = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      repeat (BITC) @(negedge clk);
    end
    rxd_i = stop_ok;
    repeat (BITC) @(negedge clk);
    rxd_i = 1'b1;
    repeat (BITC) @(negedge clk);
    if (stop_ok && rx_model_cnt < DEPTH) begin
      rxq.push_back(d);
      rx_model_cnt++;
    end
  endtask

  task automatic rx_read(input int hold, input string req);
    logic [7:0] v, exp;
    if (rxq.size() > 0) begin
      exp = rxq.pop_front();
      rx_model_cnt--;
    end else begin
      exp = 8'h00;
    end
    bus_xfer(12'h008, 1'b0, 8'h00, hold, v);
    check(v === exp, req, v, exp);
  endtask

  // monitor: decodes transmitted frames and compares with the queue
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge txd_o);
      if (!rst) begin
        repeat (BITC/2) @(negedge clk);
        check(txd_o === 1'b0, "R2 start bit", txd_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = txd_o;
        end
        repeat (BITC) @(negedge clk);
        check(txd_o === 1'b1, "R2 stop bit", txd_o, 1);
        if (txq.size() == 0) begin
          check(1'b0, "R12 unexpected tx byte", b, 0);
        end else begin
          logic [7:0] e;
          e = txq.pop_front();
          check(b === e, "R2 tx byte", b, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);

    // reset state
    #1;
    check(ack_o === 1'b0, "R1 reset ack", ack_o, 0);
    check(irq_o === 1'b0, "R7 reset irq", irq_o, 0);
    check(txd_o === 1'b1, "R2 idle txd", txd_o, 1);
    rd_check(12'h010, 8'h03, "R4 reset status");
    rd_check(12'h018, 8'h00, "R5 reset divisor");
    rd_check(12'h020, 8'h00, "R6 reset enables");

    // R1 acknowledge handshake
    @(negedge clk);
    adr_i = 12'h018; we_i = 1'b0; cyc_i = 1'b1; stb_i = 1'b1;
    #1 check(ack_o === 1'b0, "R1 ack low on request cycle", ack_o, 0);
    @(posedge clk); #1 check(ack_o === 1'b1, "R1 ack after one edge", ack_o, 1);
    repeat (3) @(posedge clk);
    #1 check(ack_o === 1'b1, "R1 ack held", ack_o, 1);
    @(negedge clk); stb_i = 1'b0;
    #1 check(ack_o === 1'b0, "R1 ack gated by stb", ack_o, 0);
    @(negedge clk); stb_i = 1'b1;
    #1 check(ack_o === 1'b0, "R1 new request starts low", ack_o, 0);
    @(posedge clk); #1 check(ack_o === 1'b1, "R1 second ack", ack_o, 1);
    @(negedge clk); cyc_i = 1'b0; stb_i = 1'b0;
    @(posedge clk);

    // R5, R6 register access
    wr(12'h018, 8'h5A);
    rd_check(12'h018, 8'h5A, "R5 divisor readback");
    wr(12'h020, 8'hFF);
    rd_check(12'h020, 8'h03, "R6 enable readback");
    #1 check(irq_o === 1'b1, "R7 tx-empty irq", irq_o, 1);
    wr(12'h020, 8'h00);
    #1 check(irq_o === 1'b0, "R7 irq disarmed", irq_o, 0);

    // R8 unmapped and read-only addresses
    wr(12'h118, 8'hAA);
    rd_check(12'h018, 8'h5A, "R8 upper address bits decoded");
    rd_check(12'h118, 8'h00, "R8 unmapped read");
    rd_check(12'h028, 8'h00, "R8 unmapped read 0x028");
    rd_check(12'h000, 8'h00, "R8 tx register reads zero");
    wr(12'h010, 8'hFF);
    wr(12'h008, 8'h77);
    rd_check(12'h010, 8'h03, "R8 writes to read-only ignored");

    wr(12'h018, 8'h01);

    // R2 / R12 transmit burst fills the queue
    tx_send(8'hA5, 1'b1);
    tx_send(8'h3C, 1'b1);
    tx_send(8'h01, 1'b1);
    tx_send(8'h80, 1'b1);
    tx_send(8'hFF, 1'b1);
    tx_send(8'h42, 1'b0);
    rd_check(12'h010, 8'h09, "R4 R12 tx full status");
    wait (txq.size() == 0);
    repeat (BITC * 2) @(posedge clk);
    rd_check(12'h010, 8'h03, "R4 tx drained");

    // R10 short glitch ignored
    @(negedge clk); rxd_i = 1'b0;
    repeat (4) @(negedge clk); rxd_i = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    rd_check(12'h010, 8'h03, "R10 glitch ignored");

    // R11 bad stop bit, then a good frame
    line_frame(8'h55, 1'b0);
    rd_check(12'h010, 8'h03, "R11 bad stop dropped");
    wr(12'h020, 8'h01);
    line_frame(8'hC3, 1'b1);
    #1 check(irq_o === 1'b1, "R7 rx irq", irq_o, 1);
    rx_read(0, "R3 R11 frame after bad stop");
    #1 check(irq_o === 1'b0, "R7 rx irq cleared", irq_o, 0);
    wr(12'h020, 8'h00);

    // R9 held read pops once
    line_frame(8'h12, 1'b1);
    line_frame(8'h34, 1'b1);
    rx_read(5, "R9 held read first");
    rx_read(0, "R9 second byte intact");

    // R12 receive overflow
    for (int i = 0; i < 5; i++) line_frame(8'h60 + 8'(i), 1'b1);
    rd_check(12'h010, 8'h06, "R4 R12 rx full status");
    for (int i = 0; i < 4; i++) rx_read(0, "R12 rx order");
    rd_check(12'h010, 8'h03, "R4 rx empty again");
    rx_read(0, "R3 empty read zero");

    check(txq.size() == 0, "R2 tx queue consumed", txq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule